// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage pipeline, where the operand value should come from. The operand can come from the register file read made during decode. It can also be bypassed from the result waiting in the execute/memory pipeline register, or from the result waiting in the memory/writeback pipeline register. The block compares the two source register numbers held in the decode/execute register against the destination register numbers of the two older instructions. It qualifies each match with that stage's write enable and with a check that the destination is not register zero.

The block is purely combinational and has no clock or reset. Its two 2-bit select outputs drive operand multiplexers that sit outside the block. When both older stages would supply the same source register, the younger instruction, which is the one in execute/memory, wins, because it holds the most recent value. The ALU, the operand multiplexers, the register file and load-use stall detection all lie outside this block.

Top module: `operand_bypass_sel`

## Requirements
- R1: `sel_a` equals 2'b10 whenever `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a`.
- R2: `sel_b` equals 2'b10 whenever `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_b`.
- R3: For either operand, the select equals 2'b01 when `mwb_wr_en` is 1, `mwb_dst` is nonzero and `mwb_dst` equals that operand's source, provided the condition of R1 (or R2 for operand B) does not hold.
- R4: When the execute/memory and memory/writeback conditions both hold for one operand, the select for that operand is 2'b10.
- R5: A stage whose write enable is 0 never causes a select of its code (2'b10 for execute/memory, 2'b01 for memory/writeback), even when its destination matches the source.
- R6: A destination of register zero never causes bypassing, even with its write enable at 1 and a source of zero.
- R7: When no bypass condition holds for an operand, its select is 2'b00 (register file). The value 2'b11 is never driven.
- R8: The two selects are computed independently. Both operands may be bypassed at once, from the same stage or from different stages.
- R9: The outputs follow the inputs combinationally, with no clock and no internal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number from decode/execute |
| src_b | input | 5 | Second source register number from decode/execute |
| exm_dst | input | 5 | Destination register number in execute/memory |
| exm_wr_en | input | 1 | Register write enable in execute/memory |
| mwb_dst | input | 5 | Destination register number in memory/writeback |
| mwb_wr_en | input | 1 | Register write enable in memory/writeback |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as `sel_a` |

## Verification
The block holds no state, so any fault in its comparators or its priority logic appears on a select output in the same cycle as the input pattern that triggers it. It also shows up one step later as the wrong data word from the reference multiplexer the bench places around the block. A missing zero-register guard only shows when a stage writes register zero while a source names register zero. An inverted priority only shows when both older stages name the same register. For these reasons the bench drives sweeps that target those two cases and adds random traffic that uses a narrow range of register numbers, so that collisions happen often.

// File: rtl/bypass_pkg.sv
// Package: shared select codes and widths for the operand bypass selector.
// Assumes a register number width fixed at build time by the parameter below.
package bypass_pkg;
    localparam int unsigned REG_W_DEF = 5;
    localparam int unsigned SEL_W     = 2;

    localparam logic [SEL_W-1:0] SEL_RF  = 2'b00;
    localparam logic [SEL_W-1:0] SEL_EXM = 2'b10;
    localparam logic [SEL_W-1:0] SEL_MWB = 2'b01;
endpackage

// File: rtl/bypass_stage_hit.sv
// Module: decides whether one older pipeline stage can supply one operand.
// Assumes register zero is hard-wired and so must never be bypassed.
module bypass_stage_hit #(
    parameter int unsigned REG_W = bypass_pkg::REG_W_DEF
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr_en,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    // Qualified match: stage writes, target is a real register, numbers agree.
    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/bypass_pick.sv
// Module: turns two stage hits into a select code, the younger stage first.
// Assumes hit_exm comes from the stage nearer to execute.
module bypass_pick (
    input  logic                           hit_exm,
    input  logic                           hit_mwb,
    output logic [bypass_pkg::SEL_W-1:0]   sel
);
    import bypass_pkg::*;

    // Priority encode: execute/memory overrides memory/writeback.
    always_comb begin
        if (hit_exm)      sel = SEL_EXM;
        else if (hit_mwb) sel = SEL_MWB;
        else              sel = SEL_RF;
    end
endmodule

// File: rtl/bypass_operand.sv
// Module: full bypass decision for one ALU operand.
// Assumes both older stages present a destination number and a write enable.
module bypass_operand #(
    parameter int unsigned REG_W = bypass_pkg::REG_W_DEF
) (
    input  logic [REG_W-1:0]              src,
    input  logic [REG_W-1:0]              exm_dst,
    input  logic                          exm_wr_en,
    input  logic [REG_W-1:0]              mwb_dst,
    input  logic                          mwb_wr_en,
    output logic [bypass_pkg::SEL_W-1:0]  sel
);
    logic hit_exm;
    logic hit_mwb;

    bypass_stage_hit #(.REG_W(REG_W)) u_hit_exm (
        .src   (src),
        .dst   (exm_dst),
        .wr_en (exm_wr_en),
        .hit   (hit_exm)
    );

    bypass_stage_hit #(.REG_W(REG_W)) u_hit_mwb (
        .src   (src),
        .dst   (mwb_dst),
        .wr_en (mwb_wr_en),
        .hit   (hit_mwb)
    );

    bypass_pick u_pick (
        .hit_exm (hit_exm),
        .hit_mwb (hit_mwb),
        .sel     (sel)
    );
endmodule

// File: rtl/operand_bypass_sel.sv
// Module: top of the execute-stage bypass selector, two independent operands.
// Assumes a purely combinational use: no clock, no reset, no stored state.
module operand_bypass_sel #(
    parameter int unsigned REG_W = bypass_pkg::REG_W_DEF
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wr_en,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             mwb_wr_en,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b
);
    localparam int unsigned NUM_OPS = 2;

    logic [REG_W-1:0]              src_vec [NUM_OPS];
    logic [bypass_pkg::SEL_W-1:0]  sel_vec [NUM_OPS];

    // Gather the operand sources into an indexable array.
    always_comb begin
        src_vec[0] = src_a;
        src_vec[1] = src_b;
    end

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        bypass_operand #(.REG_W(REG_W)) u_op (
            .src       (src_vec[op]),
            .exm_dst   (exm_dst),
            .exm_wr_en (exm_wr_en),
            .mwb_dst   (mwb_dst),
            .mwb_wr_en (mwb_wr_en),
            .sel       (sel_vec[op])
        );
    end

    // Drive the named select ports from the per-operand results.
    always_comb begin
        sel_a = sel_vec[0];
        sel_b = sel_vec[1];
    end
endmodule

// File: rtl/operand_bypass_sel_chk.sv
// Checker: port-level rules of the bypass selector, bound to every instance.
// Assumes combinational inputs; checks are skipped while any input is unknown.
module operand_bypass_sel_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic [REG_W-1:0] src_a,
    input logic [REG_W-1:0] src_b,
    input logic [REG_W-1:0] exm_dst,
    input logic             exm_wr_en,
    input logic [REG_W-1:0] mwb_dst,
    input logic             mwb_wr_en,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b
);
    logic known;

    // Only judge fully defined input patterns.
    always_comb begin
        known = !$isunknown({src_a, src_b, exm_dst, exm_wr_en, mwb_dst, mwb_wr_en});
    end

    // Immediate checks on the current input pattern and outputs.
    always_comb begin
        if (known) begin
            assert_exm_a_R1: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == src_a) || sel_a == 2'b10);
            assert_exm_b_R2: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == src_b) || sel_b == 2'b10);
            assert_mwb_a_R3: assert (!(sel_a == 2'b01) || (mwb_wr_en && mwb_dst != '0 && mwb_dst == src_a));
            assert_mwb_b_R3: assert (!(sel_b == 2'b01) || (mwb_wr_en && mwb_dst != '0 && mwb_dst == src_b));
            assert_wen_R5:   assert (!(sel_a == 2'b10 || sel_b == 2'b10) || exm_wr_en);
            assert_mwen_R5:  assert (!(sel_a == 2'b01 || sel_b == 2'b01) || mwb_wr_en);
            assert_zero_R6:  assert (!((exm_dst == '0 || !exm_wr_en) && (mwb_dst == '0 || !mwb_wr_en))
                                     || (sel_a == 2'b00 && sel_b == 2'b00));
            assert_code_R7:  assert (sel_a != 2'b11 && sel_b != 2'b11);
        end
    end
endmodule

bind operand_bypass_sel operand_bypass_sel_chk #(.REG_W(REG_W)) u_chk (
    .src_a     (src_a),
    .src_b     (src_b),
    .exm_dst   (exm_dst),
    .exm_wr_en (exm_wr_en),
    .mwb_dst   (mwb_dst),
    .mwb_wr_en (mwb_wr_en),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
);

// File: tb/sim_operand_bypass_sel.sv
`timescale 1ns/1ps
// Bench: scoreboard around the bypass selector plus a reference operand mux.
module sim_operand_bypass_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [4:0] src_a = '0, src_b = '0, exm_dst = '0, mwb_dst = '0;
    logic       exm_wr_en = 1'b0, mwb_wr_en = 1'b0;
    logic [1:0] sel_a, sel_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0]  ea;
        logic [1:0]  eb;
        logic [31:0] da;
        logic [31:0] db;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    operand_bypass_sel u0 (
        .src_a(src_a), .src_b(src_b),
        .exm_dst(exm_dst), .exm_wr_en(exm_wr_en),
        .mwb_dst(mwb_dst), .mwb_wr_en(mwb_wr_en),
        .sel_a(sel_a), .sel_b(sel_b)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Fixed data words standing in for the three operand sources.
    localparam logic [31:0] RF_A = 32'h1111_0000, RF_B = 32'h2222_0000;
    localparam logic [31:0] EXM_V = 32'hE0E0_E0E0, MWB_V = 32'h3B3B_3B3B;

    function automatic logic [31:0] ref_mux(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'b10:   return EXM_V;
            2'b01:   return MWB_V;
            2'b00:   return rf;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // Expected select from R1-style rules: younger stage first, zero register excluded.
    function automatic logic [1:0] want(input logic [4:0] s, input logic [4:0] ed, input logic ew,
                                        input logic [4:0] md, input logic mw);
        if (ew && ed != 5'd0 && ed == s) return 2'b10;
        if (mw && md != 5'd0 && md == s) return 2'b01;
        return 2'b00;
    endfunction

    // Driver: apply one pattern just after a rising edge and queue its expectation.
    task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic [4:0] ed,
                         input logic ew, input logic [4:0] md, input logic mw, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        src_a = a; src_b = b; exm_dst = ed; exm_wr_en = ew; mwb_dst = md; mwb_wr_en = mw;
        e.ea  = want(a, ed, ew, md, mw);
        e.eb  = want(b, ed, ew, md, mw);
        e.da  = ref_mux(e.ea, RF_A);
        e.db  = ref_mux(e.eb, RF_B);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: on the falling edge, compare outputs against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            logic [31:0] ga, gb;
            e  = sb_q.pop_front();
            ga = ref_mux(sel_a, RF_A);
            gb = ref_mux(sel_b, RF_B);
            n_checks += 2;
            if (sel_a !== e.ea || ga !== e.da) begin
                n_fail++;
                $display("FAIL %s operand A: sel=%b data=%h expected sel=%b data=%h", e.tag, sel_a, ga, e.ea, e.da);
            end
            if (sel_b !== e.eb || gb !== e.db) begin
                n_fail++;
                $display("FAIL %s operand B: sel=%b data=%h expected sel=%b data=%h", e.tag, sel_b, gb, e.eb, e.db);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: nothing writes, both operands read the register file (R7).
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R7 idle");
        drive(5'd3, 5'd4, 5'd9, 1'b1, 5'd10, 1'b1, "R7 no match");

        // Execute/memory match on each operand (R1, R2).
        drive(5'd5, 5'd6, 5'd5, 1'b1, 5'd0, 1'b0, "R1 exm to A");
        drive(5'd6, 5'd7, 5'd7, 1'b1, 5'd0, 1'b0, "R2 exm to B");

        // Memory/writeback match alone (R3).
        drive(5'd8, 5'd9, 5'd1, 1'b1, 5'd8, 1'b1, "R3 mwb to A");
        drive(5'd8, 5'd9, 5'd1, 1'b0, 5'd9, 1'b1, "R3 mwb to B");

        // Both stages write the same register: younger wins (R4).
        drive(5'd12, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1, "R4 double hazard");
        drive(5'd12, 5'd2, 5'd12, 1'b1, 5'd12, 1'b1, "R4 double on A only");

        // Write enables clear: matches ignored (R5).
        drive(5'd14, 5'd15, 5'd14, 1'b0, 5'd15, 1'b0, "R5 both wen clear");
        drive(5'd14, 5'd14, 5'd14, 1'b0, 5'd14, 1'b1, "R5 exm wen clear falls to mwb");

        // Register zero is never bypassed (R6).
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R6 zero both stages");
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, "R6 zero exm");
        drive(5'd0, 5'd21, 5'd0, 1'b1, 5'd21, 1'b1, "R6 zero exm with B mwb");

        // Independent operands, different stages at once (R8).
        drive(5'd17, 5'd18, 5'd17, 1'b1, 5'd18, 1'b1, "R8 A exm B mwb");
        drive(5'd18, 5'd17, 5'd17, 1'b1, 5'd18, 1'b1, "R8 A mwb B exm");
        drive(5'd19, 5'd19, 5'd19, 1'b1, 5'd0, 1'b0, "R8 both exm");

        // Sweep every register number through each stage (R1, R2, R3, R6).
        for (int r = 0; r < 32; r++) begin
            drive(5'(r), 5'(31 - r), 5'(r), 1'b1, 5'd0, 1'b0, (r == 0) ? "R6 sweep exm" : "R1 sweep exm");
            drive(5'(31 - r), 5'(r), 5'd0, 1'b0, 5'(r), 1'b1, (r == 0) ? "R6 sweep mwb" : "R3 sweep mwb");
            drive(5'(r), 5'(r), 5'(r), 1'b1, 5'(r), 1'b1, (r == 0) ? "R6 sweep both" : "R4 sweep both");
        end

        // Dense random traffic over few registers so collisions are frequent (R8, R9).
        for (int i = 0; i < 3000; i++) begin
            drive(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 1'($urandom),
                  5'($urandom % 4), 1'($urandom), "R9 random");
        end

        repeat (3) @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule